// File: doc/BRIEF.md
# Bit-Serial Lookup ALU

This block computes word-wide arithmetic and logic results one bit per clock. Its core is a one-bit datapath. A small lookup table is indexed by the operation code, the present bit of each operand and a single fed-back state bit. For every step the table returns an 8-bit word. That word holds the result bit, the next value of the state bit and spare control bits, which are brought out as auxiliary hints. The state bit carries the ripple between bit positions, so one table covers addition, subtraction, increment, shifting and the bitwise operations at any serial width.

A controller pulses `start` together with an operation code. Over the next `WIDTH` cycles it then presents the two operands least-significant bit first. Operand A comes from one serial memory stream and operand B from a second stream, both in the same cycle. Each result bit leaves through a register one cycle after its operands, so it can be written into a third serial memory while the reads continue. When the final bit has been processed, the block raises a one-cycle `done` strobe. At that point a zero flag and a carry flag describe the whole word.

Top module: `serial_lut_alu`

## Requirements
- R1: After synchronous reset `busy`, `done`, `res_valid`, `res_bit`, `zero_flag` and `carry_flag` are all 0.
- R2: A `start` pulse while `busy` is 1 is ignored: the operation in progress, its operation code and its bit count carry on unchanged.
- R3: Operands are consumed least-significant bit first, one bit per cycle, in the `WIDTH` cycles after the `start` cycle. The result bit for the operand bits sampled at one edge appears on `res_bit` with `res_valid` = 1 after that edge. `res_valid` is high for exactly `WIDTH` consecutive cycles.
- R4: Code 0 (add) gives A+B modulo 2^WIDTH, and `carry_flag` is the carry out of the top bit. The carry flag changes only at the last bit of an operation or at an accepted start, where it clears.
- R5: Code 1 (subtract) gives A-B modulo 2^WIDTH, and `carry_flag` is 1 exactly when A >= B (no borrow).
- R6: Codes 2, 3 and 4 give A AND B, A OR B and A XOR B, with `carry_flag` 0.
- R7: Code 5 copies B to the result and ignores A, with `carry_flag` 0.
- R8: Code 6 shifts A left by one (bit 0 of the result is 0, B ignored), and `carry_flag` is the top bit of A.
- R9: Code 7 gives A+1 modulo 2^WIDTH and ignores B, and `carry_flag` is 1 exactly when A is all ones.
- R10: `zero_flag` is set to 1 by an accepted start and cleared by any result bit of 1. Once cleared it stays 0 until the next accepted start, so when `done` is high it is 1 exactly when the word result is zero.
- R11: `done` is a one-cycle pulse in the same cycle as the last `res_valid`, and `busy` is 0 in that cycle.
- R12: `aux_out` carries the spare table bits with the result. Bit 0 is A AND B and bit 1 is A XOR B for the operand bits that produced it, and bits 5:2 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| op | input | 3 | Operation code, sampled with an accepted start |
| a_bit | input | 1 | Serial operand A bit |
| b_bit | input | 1 | Serial operand B bit |
| busy | output | 1 | Operand bits are being consumed |
| res_bit | output | 1 | Registered result bit |
| res_valid | output | 1 | `res_bit` holds a valid result bit |
| aux_out | output | 6 | Registered spare table bits |
| done | output | 1 | One-cycle end-of-operation strobe |
| zero_flag | output | 1 | Result-is-zero flag |
| carry_flag | output | 1 | State bit latched after the last bit |

## Verification
Each operation code is driven with directed operand pairs. For add and subtract, the operands ripple a carry or borrow across the full word: an all-ones plus one, A equal to B, A below B, and a mixed pattern. These tell a correct state feedback apart from a one-bit-only or wrongly initialised one. The bitwise, copy, shift and increment codes use alternating and asymmetric patterns with the unused operand held at ones or toggled, so operand swaps and bit-order reversal show up. A restart with a changed code in the middle of an operation, zero and non-zero results, and the last-bit timing of `done` cover the control side.

// File: rtl/slalu_pkg.sv
package slalu_pkg;

  localparam int OP_W  = 3;
  localparam int LUT_W = 8;
  localparam int AUX_W = LUT_W - 2;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_AND   = 3'd2,
    OP_OR    = 3'd3,
    OP_XOR   = 3'd4,
    OP_PASSB = 3'd5,
    OP_SHL   = 3'd6,
    OP_INC   = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic [AUX_W-1:0] aux;
    logic             next_s;
    logic             res;
  } lut_word_t;

  // value of the fed-back state bit before bit 0
  function automatic logic init_state(alu_op_e code);
    return (code == OP_SUB) || (code == OP_INC);
  endfunction

endpackage

// File: rtl/alu_lut.sv
module alu_lut
  import slalu_pkg::*;
(
  input  alu_op_e   op,
  input  logic      a,
  input  logic      b,
  input  logic      s,
  output lut_word_t word
);

  logic nb;
  assign nb = ~b;

  always_comb begin
    word        = '0;
    word.aux[0] = a & b;
    word.aux[1] = a ^ b;
    unique case (op)
      OP_ADD: begin
        word.res    = a ^ b ^ s;
        word.next_s = (a & b) | (a & s) | (b & s);
      end
      OP_SUB: begin
        word.res    = a ^ nb ^ s;
        word.next_s = (a & nb) | (a & s) | (nb & s);
      end
      OP_AND:   word.res = a & b;
      OP_OR:    word.res = a | b;
      OP_XOR:   word.res = a ^ b;
      OP_PASSB: word.res = b;
      OP_SHL: begin
        word.res    = s;
        word.next_s = a;
      end
      OP_INC: begin
        word.res    = a ^ s;
        word.next_s = a & s;
      end
      default: word = '0;
    endcase
  end

endmodule

// File: rtl/alu_bitctr.sv
module alu_bitctr #(
  parameter int WIDTH = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic launch,
  output logic busy,
  output logic last,
  output logic done
);

  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(WIDTH - 1);

  logic [CW-1:0] cnt;

  assign last = busy && (cnt == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (last) begin
          busy <= 1'b0;
          cnt  <= '0;
          done <= 1'b1;
        end
      end
    end
  end

  // R2: a running count advances by one each cycle, never restarts
  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> (busy && cnt == $past(cnt) + 1'b1));

  // R11: done is a single-cycle strobe
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/alu_flags.sv
module alu_flags (
  input  logic clk,
  input  logic rst,
  input  logic launch,
  input  logic step,
  input  logic last,
  input  logic res,
  input  logic next_s,
  output logic zero_flag,
  output logic carry_flag
);

  always_ff @(posedge clk) begin
    if (rst) begin
      zero_flag  <= 1'b0;
      carry_flag <= 1'b0;
    end else if (launch) begin
      zero_flag  <= 1'b1;
      carry_flag <= 1'b0;
    end else begin
      if (step && res) zero_flag <= 1'b0;
      if (last)        carry_flag <= next_s;
    end
  end

  // R10: once cleared, zero stays cleared until a new operation
  p_zero_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (!launch && !zero_flag) |=> !zero_flag);

  // R4: carry only moves at the last bit or an accepted start
  p_carry_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!launch && !last) |=> $stable(carry_flag));

endmodule

// File: rtl/serial_lut_alu.sv
module serial_lut_alu
  import slalu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [OP_W-1:0]  op,
  input  logic             a_bit,
  input  logic             b_bit,
  output logic             busy,
  output logic             res_bit,
  output logic             res_valid,
  output logic [AUX_W-1:0] aux_out,
  output logic             done,
  output logic             zero_flag,
  output logic             carry_flag
);

  logic      launch;
  logic      last;
  logic      state_q;
  alu_op_e   op_q;
  lut_word_t word;

  assign launch = start && !busy;

  alu_bitctr #(.WIDTH(WIDTH)) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .launch (launch),
    .busy   (busy),
    .last   (last),
    .done   (done)
  );

  alu_lut u_lut (
    .op   (op_q),
    .a    (a_bit),
    .b    (b_bit),
    .s    (state_q),
    .word (word)
  );

  alu_flags u_flags (
    .clk        (clk),
    .rst        (rst),
    .launch     (launch),
    .step       (busy),
    .last       (last),
    .res        (word.res),
    .next_s     (word.next_s),
    .zero_flag  (zero_flag),
    .carry_flag (carry_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q      <= OP_ADD;
      state_q   <= 1'b0;
      res_bit   <= 1'b0;
      res_valid <= 1'b0;
      aux_out   <= '0;
    end else begin
      res_valid <= busy;
      if (launch) begin
        op_q    <= alu_op_e'(op);
        state_q <= init_state(alu_op_e'(op));
      end else if (busy) begin
        state_q <= word.next_s;
        res_bit <= word.res;
        aux_out <= word.aux;
      end
    end
  end

  // R3: a result bit is valid exactly one cycle after a bit step
  p_valid_follows_r3: assert property (@(posedge clk) disable iff (rst)
    busy |=> res_valid);

  // R11: done coincides with the final valid bit and an idle counter
  p_done_last_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> (res_valid && !busy));

  // R2: the operation code is frozen while an operation runs
  p_op_frozen_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(op_q));

  // R12: reserved table bits stay zero
  p_aux_hi_zero_r12: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (aux_out[AUX_W-1:2] == '0));

endmodule

// File: tb/serial_lut_alu_tb.sv
`timescale 1ns/100ps
module serial_lut_alu_tb;

  localparam int W = 16;

  logic clk = 1'b0;
  logic rst, start, a_bit, b_bit;
  logic [2:0] op;
  logic busy, res_bit, res_valid, done, zero_flag, carry_flag;
  logic [5:0] aux_out;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  serial_lut_alu #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .op(op),
    .a_bit(a_bit), .b_bit(b_bit), .busy(busy),
    .res_bit(res_bit), .res_valid(res_valid), .aux_out(aux_out),
    .done(done), .zero_flag(zero_flag), .carry_flag(carry_flag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // inject: bit index at which a spurious start with a different op is pulsed (-1: none)
  task automatic run_op(input string req, input logic [2:0] code,
                        input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [W-1:0] exp_r, input logic exp_c,
                        input int inject);
    logic [W-1:0] got;
    logic [W-1:0] got_g;
    logic [W-1:0] got_p;
    logic         valid_ok;
    logic         done_early;
    got = '0; got_g = '0; got_p = '0; valid_ok = 1'b1; done_early = 1'b0;
    @(negedge clk);
    start = 1'b1; op = code;
    for (int k = 0; k <= W; k++) begin
      @(negedge clk);
      if (k >= 1) begin
        got[k-1]   = res_bit;
        got_g[k-1] = aux_out[0];
        got_p[k-1] = aux_out[1];
        if (!res_valid) valid_ok = 1'b0;
        if (k < W && done) done_early = 1'b1;
      end
      start = 1'b0;
      if (k == inject) begin
        start = 1'b1; op = code ^ 3'd1;
      end
      if (k < W) begin
        a_bit = a[k]; b_bit = b[k];
      end
    end
    check({req, " result"}, 32'(got), 32'(exp_r));
    check({req, " carry"}, 32'(carry_flag), 32'(exp_c));
    check("R10 zero", 32'(zero_flag), 32'(exp_r == '0));
    check("R3 valid span", 32'(valid_ok), 32'd1);
    check("R11 done at last bit", {30'd0, done, busy}, {30'd0, 1'b1, 1'b0});
    check("R11 done not early", 32'(done_early), 32'd0);
    check("R12 aux and", 32'(got_g), 32'(a & b));
    check("R12 aux xor", 32'(got_p), 32'(a ^ b));
    @(negedge clk);
    check("R11 done pulse ends", {30'd0, done, res_valid}, 32'd0);
  endtask

  task automatic t_reset;
    rst = 1'b1; start = 1'b0; op = '0; a_bit = 1'b0; b_bit = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset outputs",
          {26'd0, busy, done, res_valid, res_bit, zero_flag, carry_flag}, 32'd0);
  endtask

  task automatic t_add;
    run_op("R4 add", 3'd0, 16'h1234, 16'h4321, 16'h5555, 1'b0, -1);
    run_op("R4 add ripple", 3'd0, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, -1);
    run_op("R4 add mixed", 3'd0, 16'h8F0F, 16'h80F1, 16'h1000, 1'b1, -1);
  endtask

  task automatic t_sub;
    run_op("R5 sub equal", 3'd1, 16'h3C3C, 16'h3C3C, 16'h0000, 1'b1, -1);
    run_op("R5 sub borrow", 3'd1, 16'h0001, 16'h0002, 16'hFFFF, 1'b0, -1);
    run_op("R5 sub", 3'd1, 16'h9000, 16'h0FFF, 16'h8001, 1'b1, -1);
  endtask

  task automatic t_logic;
    run_op("R6 and", 3'd2, 16'hF0AA, 16'h3C55, 16'h3000, 1'b0, -1);
    run_op("R6 or", 3'd3, 16'hF0AA, 16'h3C55, 16'hFCFF, 1'b0, -1);
    run_op("R6 xor", 3'd4, 16'hF0AA, 16'h3C55, 16'hCCFF, 1'b0, -1);
  endtask

  task automatic t_misc;
    run_op("R7 pass b", 3'd5, 16'hFFFF, 16'hA5C3, 16'hA5C3, 1'b0, -1);
    run_op("R8 shl", 3'd6, 16'hC001, 16'hFFFF, 16'h8002, 1'b1, -1);
    run_op("R8 shl no carry", 3'd6, 16'h4001, 16'h5555, 16'h8002, 1'b0, -1);
    run_op("R9 inc", 3'd7, 16'h00FF, 16'hFFFF, 16'h0100, 1'b0, -1);
    run_op("R9 inc wrap", 3'd7, 16'hFFFF, 16'h1234, 16'h0000, 1'b1, -1);
  endtask

  task automatic t_restart;
    run_op("R2 restart ignored", 3'd0, 16'h0F0F, 16'h0101, 16'h1010, 1'b0, 5);
    run_op("R2 restart ignored sub", 3'd1, 16'h0005, 16'h0003, 16'h0002, 1'b1, 12);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_misc();
    t_restart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule